// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Decimal Support

This block is the purely combinational arithmetic and logic stage of an 8-bit accumulator processor. Each evaluation takes an operation code, the accumulator byte, a second operand byte and the three current status flags (carry, half-carry, signed overflow). It returns the new result byte, the new flag values and one write enable per flag. The surrounding datapath stores the result and updates only those flags whose enable is high. When an enable is low, the matching flag output simply repeats its input, so the caller may also take the flag outputs as they are.

Add and subtract produce a nibble-level half-carry and a signed overflow. The signed overflow is formed from the carries into and out of the top bit. A decimal-adjust operation uses the half-carry and the carry to correct the accumulator after binary addition of two packed BCD bytes. The compare operation leaves the accumulator unchanged and reports unsigned less-than on the carry. A separate not-equal output lets the caller decide whether to branch. Operand fetch, register files, memory addressing and single-bit operations belong to the surrounding core.

Top module: `alu8_bcd`

## Requirements
- R1: Operation codes on `op_code` are as follows: 0 add, 1 add-with-carry, 2 subtract-with-borrow, 3 AND, 4 OR, 5 XOR, 6 invert, 7 clear, 8 increment, 9 decrement, 10 rotate left, 11 rotate left through carry, 12 rotate right, 13 rotate right through carry, 14 nibble swap, 15 decimal adjust, 16 compare. For add (0) and add-with-carry (1), `result` is the low byte of acc + operand (+ `c_in` for code 1). `c_out` is the carry out of bit 7 and `ac_out` is the carry out of bit 3.
- R2: For codes 0 and 1, `ov_out` is high exactly when the signed sum leaves the range -128..127, which is when the carry into bit 7 differs from the carry out of it. All three flag enables are high.
- R3: Subtract (code 2) yields acc - operand - `c_in` modulo 256. `c_out` is high when a borrow out of bit 7 occurs, `ac_out` when a borrow out of bit 3 occurs, and `ov_out` when the signed difference leaves -128..127. All three flag enables are high.
- R4: AND, OR and XOR combine acc with the operand bitwise. Invert returns the one's complement of acc and clear returns 0x00. None of these five raises any flag enable.
- R5: Increment and decrement wrap between 0xFF and 0x00 and raise no flag enable.
- R6: Rotate left through carry returns {acc[6:0], c_in} and drives acc[7] on `c_out`. Rotate right through carry returns {c_in, acc[7:1]} and drives acc[0] on `c_out`. Only `c_we` is high for these two operations.
- R7: Plain rotate left returns {acc[6:0], acc[7]} and plain rotate right returns {acc[0], acc[7:1]}. Neither raises a flag enable.
- R8: Nibble swap returns {acc[3:0], acc[7:4]} and raises no flag enable.
- R9: Decimal adjust works in two steps. First it adds 0x06 when acc[3:0] > 9 or `ac_in` is high. It then adds 0x60 when the intermediate high nibble is > 9 or the carry so far is high. The carry so far is `c_in` ORed with the carry out of the first addition. `c_out` is the carry so far ORed with the carry out of the second addition, so an incoming carry is never cleared. Only `c_we` is high.
- R10: Compare (code 16) returns acc unchanged and sets `c_out` to (acc < operand) as unsigned values. Only `c_we` is high. `not_eq` is high exactly when acc differs from the operand, for every code.
- R11: Whenever a flag's write enable is low, that flag's output equals its input.
- R12: Codes 17 to 31 are unused: `result` equals acc, all three flag enables are low and all flag outputs equal their inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_code | input | 5 | Operation select (codes listed in R1) |
| acc_in | input | 8 | Accumulator, first operand |
| opnd_in | input | 8 | Second operand |
| c_in | input | 1 | Current carry / borrow flag |
| ac_in | input | 1 | Current half-carry flag |
| ov_in | input | 1 | Current signed overflow flag |
| result | output | 8 | Result byte |
| c_out | output | 1 | New carry flag |
| ac_out | output | 1 | New half-carry flag |
| ov_out | output | 1 | New overflow flag |
| c_we | output | 1 | Carry write enable |
| ac_we | output | 1 | Half-carry write enable |
| ov_we | output | 1 | Overflow write enable |
| not_eq | output | 1 | Accumulator differs from operand |

## Verification
Add, add-with-carry, subtract and compare are swept over every pair of bytes, with both carry-in values for the two carry-using operations. These sweeps include the half-carry boundary at 0x0F/0x10, the signed boundary at 0x7F/0x80 and the equal-operand compare. A design that takes overflow from the carry out alone would flag 0xFF + 0x01. A subtractor that reports carry rather than borrow inverts C and AC on every operation. A compare that reuses the incoming borrow is wrong whenever carry-in is set.

The decimal-adjust sweep covers every accumulator value under every flag combination. It catches a design that clears an incoming carry, one that tests the high nibble before the low correction, and one that ignores the half-carry. The unary and unused-code sweeps change all flag inputs, so a flag enable raised wrongly, or a flag output that does not repeat its input, is reported.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int DW  = 8;
  localparam int NW  = DW / 2;
  localparam int OPW = 5;

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 5'd0,
    OP_ADDC = 5'd1,
    OP_SUBB = 5'd2,
    OP_AND  = 5'd3,
    OP_OR   = 5'd4,
    OP_XOR  = 5'd5,
    OP_CPL  = 5'd6,
    OP_CLR  = 5'd7,
    OP_INC  = 5'd8,
    OP_DEC  = 5'd9,
    OP_RL   = 5'd10,
    OP_RLC  = 5'd11,
    OP_RR   = 5'd12,
    OP_RRC  = 5'd13,
    OP_SWAP = 5'd14,
    OP_DA   = 5'd15,
    OP_CMP  = 5'd16
  } alu_op_e;
endpackage

// File: rtl/alu8_addsub.sv
// Shared adder for add, add-with-carry, subtract-with-borrow and compare.
// Subtraction is done as acc + ~opnd + ~borrow; carries are inverted back
// into borrows for C and AC, while OV is the same XOR in both directions.
module alu8_addsub #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] acc,
  input  logic [DW-1:0] opnd,
  input  logic          cin,
  input  logic          sub_en,
  output logic [DW-1:0] sum,
  output logic          c_out,
  output logic          ac_out,
  output logic          ov_out
);
  localparam int NW = DW / 2;

  logic [DW-1:0] b_eff;
  logic          ci_eff;
  logic [NW:0]   lo_sum;
  logic [DW-1:0] top_in_sum;
  logic [DW:0]   full_sum;

  always_comb begin
    b_eff      = sub_en ? ~opnd : opnd;
    ci_eff     = sub_en ? ~cin : cin;
    lo_sum     = {1'b0, acc[NW-1:0]} + {1'b0, b_eff[NW-1:0]} + {{NW{1'b0}}, ci_eff};
    top_in_sum = {1'b0, acc[DW-2:0]} + {1'b0, b_eff[DW-2:0]} + {{(DW-1){1'b0}}, ci_eff};
    full_sum   = {1'b0, acc} + {1'b0, b_eff} + {{DW{1'b0}}, ci_eff};
  end

  assign sum    = full_sum[DW-1:0];
  assign c_out  = full_sum[DW] ^ sub_en;
  assign ac_out = lo_sum[NW] ^ sub_en;
  assign ov_out = top_in_sum[DW-1] ^ full_sum[DW];
endmodule

// File: rtl/alu8_bitops.sv
// Logic, inc/dec, rotate and swap operations on the accumulator.
module alu8_bitops
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_op_e       op,
  input  logic [DW-1:0] acc,
  input  logic [DW-1:0] opnd,
  input  logic          c_in,
  output logic [DW-1:0] res,
  output logic          c_rot
);
  localparam int HW = DW / 2;
  localparam logic [DW-1:0] ONE = DW'(1);

  always_comb begin
    res   = acc;
    c_rot = c_in;
    case (op)
      OP_AND:  res = acc & opnd;
      OP_OR:   res = acc | opnd;
      OP_XOR:  res = acc ^ opnd;
      OP_CPL:  res = ~acc;
      OP_CLR:  res = '0;
      OP_INC:  res = acc + ONE;
      OP_DEC:  res = acc - ONE;
      OP_RL:   res = {acc[DW-2:0], acc[DW-1]};
      OP_RLC: begin
        res   = {acc[DW-2:0], c_in};
        c_rot = acc[DW-1];
      end
      OP_RR:   res = {acc[0], acc[DW-1:1]};
      OP_RRC: begin
        res   = {c_in, acc[DW-1:1]};
        c_rot = acc[0];
      end
      OP_SWAP: res = {acc[HW-1:0], acc[DW-1:HW]};
      default: res = acc;
    endcase
  end
endmodule

// File: rtl/alu8_decadj.sv
// Two-step BCD correction of the accumulator after a binary add.
module alu8_decadj #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] acc,
  input  logic          c_in,
  input  logic          ac_in,
  output logic [DW-1:0] res,
  output logic          c_out
);
  localparam int NW = DW / 2;
  localparam logic [NW-1:0] DIGIT_MAX = NW'(9);
  localparam logic [DW:0]   LO_FIX    = (DW+1)'(6);
  localparam logic [DW:0]   HI_FIX    = LO_FIX << NW;

  logic          lo_bad, hi_bad, c_mid;
  logic [DW:0]   step1, step2;

  always_comb begin
    lo_bad = ac_in | (acc[NW-1:0] > DIGIT_MAX);
    step1  = {1'b0, acc} + (lo_bad ? LO_FIX : '0);
    c_mid  = c_in | step1[DW];
    hi_bad = c_mid | (step1[DW-1:NW] > DIGIT_MAX);
    step2  = {1'b0, step1[DW-1:0]} + (hi_bad ? HI_FIX : '0);
  end

  assign res   = step2[DW-1:0];
  assign c_out = c_mid | step2[DW];
endmodule

// File: rtl/alu8_bcd.sv
// Top: operation decode, result select and per-flag write enables.
module alu8_bcd
  import alu8_pkg::*;
(
  input  logic [OPW-1:0] op_code,
  input  logic [DW-1:0]  acc_in,
  input  logic [DW-1:0]  opnd_in,
  input  logic           c_in,
  input  logic           ac_in,
  input  logic           ov_in,
  output logic [DW-1:0]  result,
  output logic           c_out,
  output logic           ac_out,
  output logic           ov_out,
  output logic           c_we,
  output logic           ac_we,
  output logic           ov_we,
  output logic           not_eq
);
  alu_op_e       op;
  logic          as_cin, as_sub;
  logic [DW-1:0] as_sum, bit_res, da_res;
  logic          as_c, as_ac, as_ov, bit_c, da_c;

  assign op     = alu_op_e'(op_code);
  assign as_cin = (op == OP_ADDC) || (op == OP_SUBB) ? c_in : 1'b0;
  assign as_sub = (op == OP_SUBB) || (op == OP_CMP);

  alu8_addsub #(.DW(DW)) u_addsub (
    .acc(acc_in), .opnd(opnd_in), .cin(as_cin), .sub_en(as_sub),
    .sum(as_sum), .c_out(as_c), .ac_out(as_ac), .ov_out(as_ov)
  );

  alu8_bitops #(.DW(DW)) u_bitops (
    .op(op), .acc(acc_in), .opnd(opnd_in), .c_in(c_in),
    .res(bit_res), .c_rot(bit_c)
  );

  alu8_decadj #(.DW(DW)) u_decadj (
    .acc(acc_in), .c_in(c_in), .ac_in(ac_in),
    .res(da_res), .c_out(da_c)
  );

  always_comb begin
    result = acc_in;
    c_out  = c_in;
    ac_out = ac_in;
    ov_out = ov_in;
    c_we   = 1'b0;
    ac_we  = 1'b0;
    ov_we  = 1'b0;
    case (op)
      OP_ADD, OP_ADDC, OP_SUBB: begin
        result = as_sum;
        c_out  = as_c;
        ac_out = as_ac;
        ov_out = as_ov;
        c_we   = 1'b1;
        ac_we  = 1'b1;
        ov_we  = 1'b1;
      end
      OP_AND, OP_OR, OP_XOR, OP_CPL, OP_CLR, OP_INC, OP_DEC,
      OP_RL, OP_RR, OP_SWAP: begin
        result = bit_res;
      end
      OP_RLC, OP_RRC: begin
        result = bit_res;
        c_out  = bit_c;
        c_we   = 1'b1;
      end
      OP_DA: begin
        result = da_res;
        c_out  = da_c;
        c_we   = 1'b1;
      end
      OP_CMP: begin
        c_out = as_c;
        c_we  = 1'b1;
      end
      default: result = acc_in;
    endcase
  end

  assign not_eq = |(acc_in ^ opnd_in);
endmodule

// File: rtl/alu8_bcd_chk.sv
module alu8_bcd_chk
  import alu8_pkg::*;
(
  input logic [OPW-1:0] op_code,
  input logic [DW-1:0]  acc_in,
  input logic [DW-1:0]  opnd_in,
  input logic           c_in,
  input logic           ac_in,
  input logic           ov_in,
  input logic [DW-1:0]  result,
  input logic           c_out,
  input logic           ac_out,
  input logic           ov_out,
  input logic           c_we,
  input logic           ac_we,
  input logic           ov_we,
  input logic           not_eq
);
  logic is_arith, is_quiet, is_unused;

  always_comb begin
    is_arith  = (op_code == OP_ADD) || (op_code == OP_ADDC) || (op_code == OP_SUBB);
    is_quiet  = (op_code >= OP_AND) && (op_code <= OP_DEC);
    is_unused = op_code > OP_CMP;

    AST_ARITH_ALL_WE: assert (!is_arith || (c_we && ac_we && ov_we)) else $error("arith enables"); // R1
    AST_ADD_SIGN_OV: assert (!(op_code == OP_ADD && acc_in[7] == opnd_in[7] && result[7] != acc_in[7]) || ov_out) else $error("add overflow missed"); // R2
    AST_SUB_BORROW: assert (!(op_code == OP_SUBB && !c_in) || (c_out == (acc_in < opnd_in))) else $error("sub borrow"); // R3
    AST_QUIET_NO_WE: assert (!is_quiet || !(c_we || ac_we || ov_we)) else $error("quiet op raised enable"); // R4
    AST_RLC_CARRY: assert (!(op_code == OP_RLC) || (c_out == acc_in[7] && result[0] == c_in)) else $error("rlc"); // R6
    AST_SWAP_NIB: assert (!(op_code == OP_SWAP) || (result[3:0] == acc_in[7:4] && result[7:4] == acc_in[3:0])) else $error("swap"); // R8
    AST_DA_KEEP_C: assert (!(op_code == OP_DA && c_in) || c_out) else $error("da cleared carry"); // R9
    AST_CMP_FLAGS: assert (!(op_code == OP_CMP) || (result == acc_in && c_out == (acc_in < opnd_in) && !ac_we && !ov_we)) else $error("cmp"); // R10
    AST_NE_OUT: assert (not_eq == (acc_in != opnd_in)) else $error("not_eq"); // R10
    AST_HOLD_FLAGS: assert ((c_we || c_out == c_in) && (ac_we || ac_out == ac_in) && (ov_we || ov_out == ov_in)) else $error("flag hold"); // R11
    AST_UNUSED_CODE: assert (!is_unused || (result == acc_in && !c_we && !ac_we && !ov_we)) else $error("unused code"); // R12
  end
endmodule

bind alu8_bcd alu8_bcd_chk u_chk (.*);

// File: tb/alu8_bcd_test.sv
module alu8_bcd_test;
  localparam int C_ADD = 0, C_ADDC = 1, C_SUBB = 2, C_AND = 3, C_OR = 4, C_XOR = 5;
  localparam int C_CPL = 6, C_CLR = 7, C_INC = 8, C_DEC = 9, C_RL = 10, C_RLC = 11;
  localparam int C_RR = 12, C_RRC = 13, C_SWAP = 14, C_DA = 15, C_CMP = 16;
  localparam int WATCHDOG = 190000;

  logic       clk = 1'b0;
  logic [4:0] op_code = '0;
  logic [7:0] acc_in = '0, opnd_in = '0;
  logic       c_in = 1'b0, ac_in = 1'b0, ov_in = 1'b0;
  logic [7:0] result;
  logic       c_out, ac_out, ov_out, c_we, ac_we, ov_we, not_eq;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  int e_res, e_c, e_ac, e_ov, e_cwe, e_acwe, e_ovwe, e_ne;

  always #4 clk = ~clk;

  alu8_bcd uut (.*);

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc == WATCHDOG) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: run did not end, actual cycles %0d expected < %0d", cyc, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  function automatic int sgn(input int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  function automatic string tag_of(input int op);
    case (op)
      C_ADD, C_ADDC: return "R1 R2";
      C_SUBB: return "R3";
      C_AND, C_OR, C_XOR, C_CPL, C_CLR: return "R4 R11";
      C_INC, C_DEC: return "R5 R11";
      C_RLC, C_RRC: return "R6 R11";
      C_RL, C_RR: return "R7 R11";
      C_SWAP: return "R8 R11";
      C_DA: return "R9 R11";
      C_CMP: return "R10 R11";
      default: return "R12";
    endcase
  endfunction

  task automatic model(input int op, input int a, input int b, input int ci, input int aci, input int ovi);
    int cc, s, t, v;
    e_res = a; e_c = ci; e_ac = aci; e_ov = ovi;
    e_cwe = 0; e_acwe = 0; e_ovwe = 0;
    e_ne  = (a != b) ? 1 : 0;
    case (op)
      C_ADD, C_ADDC: begin
        cc = (op == C_ADDC) ? ci : 0;
        s = a + b + cc;
        e_res = s % 256;
        e_c  = (s > 255) ? 1 : 0;
        e_ac = (((a % 16) + (b % 16) + cc) > 15) ? 1 : 0;
        t = sgn(a) + sgn(b) + cc;
        e_ov = (t > 127 || t < -128) ? 1 : 0;
        e_cwe = 1; e_acwe = 1; e_ovwe = 1;
      end
      C_SUBB: begin
        s = a - b - ci;
        e_res = (s + 256) % 256;
        e_c  = (s < 0) ? 1 : 0;
        e_ac = ((a % 16) < (b % 16) + ci) ? 1 : 0;
        t = sgn(a) - sgn(b) - ci;
        e_ov = (t > 127 || t < -128) ? 1 : 0;
        e_cwe = 1; e_acwe = 1; e_ovwe = 1;
      end
      C_AND:  e_res = a & b;
      C_OR:   e_res = a | b;
      C_XOR:  e_res = a ^ b;
      C_CPL:  e_res = 255 - a;
      C_CLR:  e_res = 0;
      C_INC:  e_res = (a + 1) % 256;
      C_DEC:  e_res = (a + 255) % 256;
      C_RL:   e_res = ((a * 2) % 256) + a / 128;
      C_RLC:  begin e_res = ((a * 2) % 256) + ci; e_c = a / 128; e_cwe = 1; end
      C_RR:   e_res = a / 2 + (a % 2) * 128;
      C_RRC:  begin e_res = a / 2 + ci * 128; e_c = a % 2; e_cwe = 1; end
      C_SWAP: e_res = (a % 16) * 16 + a / 16;
      C_DA: begin
        v = a;
        if ((a % 16) > 9 || aci == 1) v = v + 6;
        e_c = (ci == 1 || v > 255) ? 1 : 0;
        v = v % 256;
        if ((v / 16) > 9 || e_c == 1) v = v + 96;
        if (v > 255) e_c = 1;
        e_res = v % 256;
        e_cwe = 1;
      end
      C_CMP: begin e_c = (a < b) ? 1 : 0; e_cwe = 1; end
      default: e_res = a;
    endcase
  endtask

  task automatic run(input int op, input int a, input int b, input int ci, input int aci, input int ovi);
    op_code = 5'(op); acc_in = 8'(a); opnd_in = 8'(b);
    c_in = 1'(ci); ac_in = 1'(aci); ov_in = 1'(ovi);
    model(op, a, b, ci, aci, ovi);
    #1;
    n_cmp = n_cmp + 1;
    if (int'(result) != e_res || int'(c_out) != e_c || int'(ac_out) != e_ac ||
        int'(ov_out) != e_ov || int'(c_we) != e_cwe || int'(ac_we) != e_acwe ||
        int'(ov_we) != e_ovwe || int'(not_eq) != e_ne) begin
      n_bad = n_bad + 1;
      if (n_bad <= 20)
        $display("FAIL %s op=%0d a=%02h b=%02h ci=%0d ac=%0d ov=%0d: actual res=%02h c=%0d ac=%0d ov=%0d we=%0d%0d%0d ne=%0d expected res=%02h c=%0d ac=%0d ov=%0d we=%0d%0d%0d ne=%0d",
                 tag_of(op), op, a, b, ci, aci, ovi,
                 result, c_out, ac_out, ov_out, c_we, ac_we, ov_we, not_eq,
                 e_res, e_c, e_ac, e_ov, e_cwe, e_acwe, e_ovwe, e_ne);
    end
    #1;
  endtask

  initial begin
    #2;
    // Idle state: unused code with all zero inputs (R12)
    run(31, 0, 0, 0, 0, 0);
    // R1 R2: add over every byte pair; add-with-carry with both carry-in values
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++) begin
        run(C_ADD, a, b, (a ^ b) & 1, 0, 1);
        run(C_ADDC, a, b, 0, 1, 0);
        run(C_ADDC, a, b, 1, 0, 1);
      end
    // R3 subtract-with-borrow, both borrows; R10 compare with either carry-in
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++) begin
        run(C_SUBB, a, b, 0, 1, 1);
        run(C_SUBB, a, b, 1, 0, 0);
        run(C_CMP, a, b, b & 1, a & 1, 1);
      end
    // R4 bitwise logic with flag inputs varied (flags must pass through)
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b += 3) begin
        run(C_AND, a, b, a & 1, b & 1, (a >> 1) & 1);
        run(C_OR,  a, b, b & 1, a & 1, (b >> 1) & 1);
        run(C_XOR, a, b, (a >> 2) & 1, (b >> 2) & 1, a & 1);
      end
    // R4..R9, R11: unary operations over every accumulator and flag combination
    for (int a = 0; a < 256; a++)
      for (int f = 0; f < 8; f++) begin
        run(C_CPL,  a, 255 - a, f & 1, (f >> 1) & 1, (f >> 2) & 1);
        run(C_CLR,  a, a, f & 1, (f >> 1) & 1, (f >> 2) & 1);
        run(C_INC,  a, 0, f & 1, (f >> 1) & 1, (f >> 2) & 1);
        run(C_DEC,  a, 0, f & 1, (f >> 1) & 1, (f >> 2) & 1);
        run(C_RL,   a, 1, f & 1, (f >> 1) & 1, (f >> 2) & 1);
        run(C_RLC,  a, 1, f & 1, (f >> 1) & 1, (f >> 2) & 1);
        run(C_RR,   a, 2, f & 1, (f >> 1) & 1, (f >> 2) & 1);
        run(C_RRC,  a, 2, f & 1, (f >> 1) & 1, (f >> 2) & 1);
        run(C_SWAP, a, 3, f & 1, (f >> 1) & 1, (f >> 2) & 1);
        run(C_DA,   a, 4, f & 1, (f >> 1) & 1, (f >> 2) & 1);
      end
    // R12: every unused code, flags varied
    for (int op = 17; op < 32; op++)
      for (int a = 0; a < 256; a += 5)
        for (int f = 0; f < 8; f++)
          run(op, a, 255 - a, f & 1, (f >> 1) & 1, (f >> 2) & 1);
    // R9 named corners: 0x99+carry, 0x9A, 0x0F with half-carry
    run(C_DA, 8'h99, 0, 1, 0, 0);
    run(C_DA, 8'h9A, 0, 0, 0, 0);
    run(C_DA, 8'h0F, 0, 0, 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule